// File: doc/BRIEF.md
# Paged Fetch Address Generator with Return Stack

This block produces the instruction fetch address for a small 8-bit controller core whose program space holds 8K words and is addressed by a 13-bit counter. Each clock the core hands it one decoded operation. The operation can advance the counter by one, branch to an 11-bit immediate placed in a page chosen by two bits of an external page latch, call a subroutine, return, enter the interrupt vector, or overwrite the low byte of the counter for a computed jump.

A call or an interrupt entry saves a return address in an 8-entry hardware stack. A return restores that address. Software cannot see the stack or its pointer. The stack is a circular buffer with no overflow or underflow indication. Once more than eight addresses are saved, the newest ones overwrite the oldest ones. Popping more often than pushing simply moves the pointer backwards around the ring.

Top module: `fetch_pc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the counter output is 0.
- R2: Operation code 0 (advance) sets the counter to its value plus one, modulo 2^13, so 0x1FFF is followed by 0x0000.
- R3: Operation code 1 (jump) loads the counter with {page_latch bit 4, page_latch bit 3, 11-bit immediate}.
- R4: Operation code 2 (call) loads the same paged target as a jump and saves the counter value plus one on the stack.
- R5: Operation code 3 (return) loads all 13 counter bits from the most recently saved stack entry, whatever the page latch holds, and removes that entry.
- R6: Operation code 4 (low-byte write) loads the counter with {page_latch bits 4:0, 8-bit data}.
- R7: Operation code 5 (interrupt entry) loads the counter with 0x004 and saves the unchanged current counter value on the stack.
- R8: The stack holds 8 entries in a ring. The ninth save overwrites the first, the tenth overwrites the second, and returns always come back in last-in-first-out order over the surviving entries.
- R9: Page latch bits 7:5 have no effect on any operation, and bits 2:0 have no effect on jump or call targets.
- R10: Operation codes 6 and 7 behave exactly like operation code 0.
- R11: A return taken when every saved entry has already been removed wraps the stack pointer. After eight saves and eight returns, a further return yields the entry of the eighth save again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Decoded operation code for this cycle |
| imm_i | input | 11 | Branch immediate for jump and call |
| data_i | input | 8 | New low byte for a computed jump |
| latch_i | input | 8 | Page latch register contents |
| pc_o | output | 13 | Current fetch address |

## Verification
A wrong stack pointer or a corrupted stack entry does not show when it happens. It shows only at the port, on the first return that reads the bad slot, which can be many operations later. The tests therefore always finish with returns that drain the stack completely, including a drain past the wrap point and one extra return. A wrong page or low-byte merge shows on the counter in the very next cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    PCU_ADV   = 3'd0,
    PCU_JMP   = 3'd1,
    PCU_CALL  = 3'd2,
    PCU_RET   = 3'd3,
    PCU_WRLO  = 3'd4,
    PCU_IRQ   = 3'd5,
    PCU_ADV_A = 3'd6,
    PCU_ADV_B = 3'd7
  } pcu_op_e;
endpackage

// File: rtl/pcu_stack.sv
// Circular return-address ring; DEPTH must be a power of two so the
// pointer wraps by plain overflow.
module pcu_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic [W-1:0]             wdata_i,
  output logic [W-1:0]             top_o,
  output logic [$clog2(DEPTH)-1:0] ptr_o
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] top_idx;
  logic [W-1:0]  slots [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_q + 1'b1;
    else if (pop_i)  ptr_q <= ptr_q - 1'b1;
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (push_i && ptr_q == PW'(i)) slot_q <= wdata_i;
      end
      assign slots[i] = slot_q;
    end
  endgenerate

  assign top_idx = ptr_q - 1'b1;
  assign top_o   = slots[top_idx];
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int IMM_W  = 11,
  parameter int DATA_W = 8,
  parameter int LAT_W  = 8,
  parameter int VEC    = 4
) (
  input  logic [2:0]        op_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LAT_W-1:0]  latch_i,
  input  logic [PC_W-1:0]   stk_top_i,
  output logic [PC_W-1:0]   pc_next_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [PC_W-1:0]   push_val_o
);
  localparam int HI_W   = PC_W - DATA_W;
  localparam int PAGE_W = PC_W - IMM_W;

  function automatic logic [PC_W-1:0] f_seq(input logic [PC_W-1:0] pc);
    return pc + 1'b1;
  endfunction

  function automatic logic [PC_W-1:0] f_paged(input logic [LAT_W-1:0] lat,
                                              input logic [IMM_W-1:0] imm);
    return {lat[HI_W-1 -: PAGE_W], imm};
  endfunction

  function automatic logic [PC_W-1:0] f_lowbyte(input logic [LAT_W-1:0] lat,
                                                input logic [DATA_W-1:0] dat);
    return {lat[HI_W-1:0], dat};
  endfunction

  pcu_op_e op;
  assign op = pcu_op_e'(op_i);

  always_comb begin
    pc_next_o  = f_seq(pc_i);
    push_o     = 1'b0;
    pop_o      = 1'b0;
    push_val_o = f_seq(pc_i);
    unique case (op)
      PCU_JMP:  pc_next_o = f_paged(latch_i, imm_i);
      PCU_CALL: begin
        pc_next_o = f_paged(latch_i, imm_i);
        push_o    = 1'b1;
      end
      PCU_RET: begin
        pc_next_o = stk_top_i;
        pop_o     = 1'b1;
      end
      PCU_WRLO: pc_next_o = f_lowbyte(latch_i, data_i);
      PCU_IRQ: begin
        pc_next_o  = PC_W'(VEC);
        push_o     = 1'b1;
        push_val_o = pc_i;
      end
      default:  pc_next_o = f_seq(pc_i);
    endcase
  end
endmodule

// File: rtl/fetch_pc.sv
module fetch_pc #(
  parameter int PC_W   = 13,
  parameter int IMM_W  = 11,
  parameter int DATA_W = 8,
  parameter int LAT_W  = 8,
  parameter int DEPTH  = 8,
  parameter int VEC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LAT_W-1:0]  latch_i,
  output logic [PC_W-1:0]   pc_o
);
  localparam int PW = $clog2(DEPTH);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_next_w;
  logic            push_w;
  logic            pop_w;
  logic [PC_W-1:0] push_val_w;
  logic [PC_W-1:0] stk_top_w;
  logic [PW-1:0]   stk_ptr_w;

  pcu_next #(
    .PC_W(PC_W), .IMM_W(IMM_W), .DATA_W(DATA_W), .LAT_W(LAT_W), .VEC(VEC)
  ) u_next (
    .op_i(op_i), .pc_i(pc_q), .imm_i(imm_i), .data_i(data_i),
    .latch_i(latch_i), .stk_top_i(stk_top_w), .pc_next_o(pc_next_w),
    .push_o(push_w), .pop_o(pop_w), .push_val_o(push_val_w)
  );

  pcu_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push_w), .pop_i(pop_w),
    .wdata_i(push_val_w), .top_o(stk_top_w), .ptr_o(stk_ptr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next_w;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/fetch_pc_checker.sv
module fetch_pc_checker #(
  parameter int PC_W   = 13,
  parameter int IMM_W  = 11,
  parameter int DATA_W = 8,
  parameter int LAT_W  = 8,
  parameter int DEPTH  = 8,
  parameter int VEC    = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               op_i,
  input logic [IMM_W-1:0]         imm_i,
  input logic [DATA_W-1:0]        data_i,
  input logic [LAT_W-1:0]         latch_i,
  input logic [PC_W-1:0]          pc_o,
  input logic                     push_w,
  input logic                     pop_w,
  input logic [PC_W-1:0]          stk_top_w,
  input logic [$clog2(DEPTH)-1:0] stk_ptr_w
);
  localparam int PW = $clog2(DEPTH);

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0) |=> pc_o == PC_W'($past(pc_o) + 1'b1));
  a_r10_spare_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 3'd6) |=> pc_o == PC_W'($past(pc_o) + 1'b1));
  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1) |=> pc_o == {$past(latch_i[4:3]), $past(imm_i)});
  a_r4_call_saves_next: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2) |=> stk_top_w == PC_W'($past(pc_o) + 1'b1)
                       && pc_o == {$past(latch_i[4:3]), $past(imm_i)});
  a_r5_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3) |=> pc_o == $past(stk_top_w));
  a_r6_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4) |=> pc_o == {$past(latch_i[4:0]), $past(data_i)});
  a_r7_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd5) |=> pc_o == PC_W'(VEC) && stk_top_w == $past(pc_o));
  a_r8_ptr_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_w |=> stk_ptr_w == PW'($past(stk_ptr_w) + 1'b1));
  a_r11_ptr_pop_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    pop_w |=> stk_ptr_w == PW'($past(stk_ptr_w) - 1'b1));
  a_r8_one_stack_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_w, pop_w}));
endmodule

bind fetch_pc fetch_pc_checker #(
  .PC_W(PC_W), .IMM_W(IMM_W), .DATA_W(DATA_W), .LAT_W(LAT_W),
  .DEPTH(DEPTH), .VEC(VEC)
) u_fetch_pc_checker (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i), .data_i(data_i),
  .latch_i(latch_i), .pc_o(pc_o), .push_w(push_w), .pop_w(pop_w),
  .stk_top_w(stk_top_w), .stk_ptr_w(stk_ptr_w)
);

// File: tb/fetch_pc_bench.sv
`timescale 1ns/1ps
module fetch_pc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [10:0] imm_i = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  latch_i = '0;
  logic [12:0] pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [12:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  // independent reference model
  logic [12:0] m_pc = '0;
  logic [12:0] m_stk [8];
  int          m_sp = 0;

  always #10 clk = ~clk;

  fetch_pc u_fetch_pc (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i),
    .data_i(data_i), .latch_i(latch_i), .pc_o(pc_o)
  );

  task automatic check(input logic [12:0] act, input logic [12:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: pc actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int op, input int imm, input int dat,
                       input int lat, input string tag);
    logic [12:0] nxt;
    @(negedge clk);
    op_i = 3'(op); imm_i = 11'(imm); data_i = 8'(dat); latch_i = 8'(lat);
    case (op)
      1: nxt = (13'(lat) & 13'h18) << 8 | 13'(imm);
      2: begin
        m_stk[m_sp] = m_pc + 13'd1; m_sp = (m_sp + 1) % 8;
        nxt = (13'(lat) & 13'h18) << 8 | 13'(imm);
      end
      3: begin
        m_sp = (m_sp + 7) % 8; nxt = m_stk[m_sp];
      end
      4: nxt = (13'(lat) & 13'h1F) * 13'd256 + 13'(dat);
      5: begin
        m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; nxt = 13'd4;
      end
      default: nxt = (m_pc == 13'h1FFF) ? 13'd0 : m_pc + 13'd1;
    endcase
    m_pc = nxt;
    sb.push_back('{exp: nxt, tag: tag});
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(pc_o, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pc_o, 13'd0, "R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(pc_o, 13'd1, "R1 first advance after reset");
    m_pc = 13'd1;
    // advance and spare codes
    do_op(0, 0, 0, 0, "R2 advance");
    do_op(6, 0, 0, 0, "R10 code 6");
    do_op(7, 0, 0, 0, "R10 code 7");
    // jump with junk in ignored latch bits
    do_op(1, 'h5A3, 0, 'hEF, "R3 R9 jump page 1");
    do_op(1, 'h7FF, 0, 'h18, "R3 jump page 3 top");
    // low-byte write and counter wrap
    do_op(4, 0, 'hFF, 'hFF, "R6 R9 low byte");
    do_op(0, 0, 0, 0, "R2 wrap to zero");
    do_op(4, 0, 'h3C, 'h0A, "R6 computed jump");
    // nested calls and returns across pages
    do_op(2, 'h123, 0, 'h10, "R4 call page 2");
    do_op(0, 0, 0, 0, "R2 in callee");
    do_op(2, 'h456, 0, 'h08, "R4 nested call");
    do_op(3, 0, 0, 'hFF, "R5 return ignores latch");
    do_op(3, 0, 0, 'h00, "R5 return outer");
    // interrupt entry and exit
    do_op(5, 0, 0, 'h18, "R7 interrupt vector");
    do_op(0, 0, 0, 0, "R2 in handler");
    do_op(3, 0, 0, 'h18, "R7 resume interrupted address");
    // ring overflow: ten saves, ten returns
    for (int i = 0; i < 10; i++)
      do_op(2, 'h100 + 17 * i, 0, (i % 4) << 3, "R8 call fill");
    for (int i = 0; i < 10; i++)
      do_op(3, 0, 0, 'hFF, "R8 return drain");
    // eight saves, eight returns, one extra
    for (int i = 0; i < 8; i++)
      do_op(2, 'h200 + 5 * i, 0, 'h08, "R11 call fill");
    for (int i = 0; i < 8; i++)
      do_op(3, 0, 0, 0, "R11 return drain");
    do_op(3, 0, 0, 0, "R11 extra return wraps");
    do_op(0, 0, 0, 0, "R2 after wrap");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule